// File: doc/BRIEF.md
# DMA Translation Unit Register Bank

This block is the software-visible register bank of a DMA address-translation unit. A host reaches it over a simple 32-bit word bus: one request cycle carries a byte address, a write flag and write data, and read data comes back one cycle later. Each register applies its own write mask and hardwired bits. The bank holds the translation control word, the page-table base, two flush registers (stored only), the fault status and fault address pair, two arbitration words, a set of per-slot configuration words and an accumulating mask ID.

The translation engine uses the bank in two ways. It reads the enable bit and the start of the translation window, which is decoded from a range field in the control word. It also reports faults, which the bank records in the fault pair while raising a level interrupt. Any read or write of either fault register drops the interrupt again. Offsets that name no register go to a small scratch store and keep the full written word.

Top module: `dmat_regbank`

## Requirements
- R1: Only whole 32-bit words are accessed. The word index is the byte address shifted right by two. A read request returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request.
- R2: After reset, control reads VERSION<<24 and arbitration enable reads 0x00000008. Fault status reads 0x00800000, arbiter enable reads 0x00000003 and mask ID reads 0x23000000. Every other named register reads 0 and `irq` is low.
- R3: A write to control (offset 0x0000) keeps the bits under 0x0000001D and forces bits 31:24 to VERSION. `xlat_enable` follows control bit 0.
- R4: With range field r in control bits 4:2, `win_start` equals 0xFFFFFFFF shifted left by 24+r. The window therefore starts at 0xFF000000 for r=0 and at 0x80000000 for r=7, and the reset value is 0xFF000000.
- R5: The base register (0x0004) keeps the bits under 0x07FFFC00. The slot configuration words (0x1010, 0x1014, 0x1018, 0x101C for slots 0 to 3) each keep the bits under 0x00010003 on their own. The two flush registers (0x0014, 0x0018) store the full word.
- R6: A write to arbiter enable (0x1008) keeps the bits under 0x801F000F and forces bit 0 to 1. A write to arbitration enable (0x2000) keeps the bits under 0x001F0000 and forces bit 3 to 1.
- R7: A write to fault status (0x1000) keeps the bits under 0xFF0FFFFF and forces bit 23 to 1. A write to fault address (0x1004) stores the full word.
- R8: A read or a write of fault status or fault address drives `irq` low from the next cycle.
- R9: A write to mask ID (0x3018) ORs the written value, masked by 0x00FFFFFF, into the current contents. Bits that are already set stay set.
- R10: A fault report (`flt_valid`) sets fault status to 0xC0820000, or to 0xC0860000 when `flt_read` is high. It also sets fault address to `flt_addr` with its low 12 bits cleared and raises `irq` from the next cycle.
- R11: When a fault report and a software access to a fault register fall in the same cycle, the fault report wins: both fault registers take the reported values and `irq` ends high.
- R12: A write to an offset that names no register stores the full word in a scratch store indexed by the low SCR_AW bits of the word index. A later read of that offset returns the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| flt_valid | input | 1 | Fault report from the translation engine |
| flt_read | input | 1 | Faulting access was a read |
| flt_addr | input | 32 | Faulting address |
| xlat_enable | output | 1 | Translation enable (control bit 0) |
| win_start | output | 32 | Decoded start of the translation window |
| irq | output | 1 | Level fault interrupt |

## Verification
The hardest situation to create from the ports is a fault report that lands in the very cycle of a software write to fault status. In that cycle two sources fight over the same register and the interrupt is both set and cleared. The bench drives `flt_valid` and a fault-status write from the same falling edge. It then checks that `irq` stayed high and that a read-back shows the reported status and not the written one. The OR-accumulating mask ID is covered by a sequence of partial writes, including one made only of masked-off bits.

// File: rtl/dmat_pkg.sv
package dmat_pkg;
  // word indices (byte offset >> 2); software depends on these
  localparam int unsigned IX_CTRL   = 'h000;
  localparam int unsigned IX_BASE   = 'h001;
  localparam int unsigned IX_TLBF   = 'h005;
  localparam int unsigned IX_PGF    = 'h006;
  localparam int unsigned IX_FSTAT  = 'h400;
  localparam int unsigned IX_FADDR  = 'h401;
  localparam int unsigned IX_ARB    = 'h402;
  localparam int unsigned IX_SLOT0  = 'h404;
  localparam int unsigned IX_ARBEN  = 'h800;
  localparam int unsigned IX_MASKID = 'hC06;

  localparam logic [31:0] CTRL_KEEP   = 32'h0000_001D;
  localparam logic [31:0] BASE_KEEP   = 32'h07FF_FC00;
  localparam logic [31:0] SLOT_KEEP   = 32'h0001_0003;
  localparam logic [31:0] ARB_KEEP    = 32'h801F_000F;
  localparam logic [31:0] ARB_FORCE   = 32'h0000_0001;
  localparam logic [31:0] ARBEN_KEEP  = 32'h001F_0000;
  localparam logic [31:0] ARBEN_FORCE = 32'h0000_0008;
  localparam logic [31:0] FSTAT_KEEP  = 32'hFF0F_FFFF;
  localparam logic [31:0] FSTAT_FORCE = 32'h0080_0000;
  localparam logic [31:0] MASKID_KEEP = 32'h00FF_FFFF;

  localparam logic [31:0] ARB_RST     = 32'h0000_0003;
  localparam logic [31:0] MASKID_RST  = 32'h2300_0000;

  localparam logic [31:0] FLT_STAT    = 32'hC082_0000;
  localparam logic [31:0] FLT_RD_BIT  = 32'h0004_0000;
  localparam logic [31:0] PAGE_MASK   = 32'hFFFF_F000;
endpackage

// File: rtl/dmat_window_decode.sv
module dmat_window_decode (
  input  logic [2:0]  range_sel,
  output logic [31:0] start
);
  logic [4:0] shamt;
  assign shamt = 5'd24 + {2'b00, range_sel};
  assign start = 32'hFFFF_FFFF << shamt;
endmodule

// File: rtl/dmat_scratch_ram.sv
module dmat_scratch_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dmat_fault_regs.sv
module dmat_fault_regs (
  input  logic        clk,
  input  logic        rst,
  input  logic        flt_valid,
  input  logic        flt_read,
  input  logic [31:0] flt_addr,
  input  logic        wr_stat,
  input  logic        wr_addr,
  input  logic        sw_touch,
  input  logic [31:0] wdata,
  output logic [31:0] stat_q,
  output logic [31:0] addr_q,
  output logic        irq
);
  import dmat_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= FSTAT_FORCE;
      addr_q <= '0;
      irq    <= 1'b0;
    end else if (flt_valid) begin
      stat_q <= FLT_STAT | (flt_read ? FLT_RD_BIT : 32'h0);
      addr_q <= flt_addr & PAGE_MASK;
      irq    <= 1'b1;
    end else begin
      if (wr_stat) stat_q <= (wdata & FSTAT_KEEP) | FSTAT_FORCE;
      if (wr_addr) addr_q <= wdata;
      if (sw_touch) irq <= 1'b0;
    end
  end

  // R10
  fault_raise_chk: assert property (@(posedge clk) disable iff (rst)
    flt_valid |=> irq);

  // R8
  touch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_touch && !flt_valid) |=> !irq);

  // R11
  fault_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && wr_stat) |=> stat_q[31]);
endmodule

// File: rtl/dmat_regbank.sv
module dmat_regbank #(
  parameter int          ADDR_W    = 14,
  parameter logic [7:0]  VERSION   = 8'h04,
  parameter int          NUM_SLOTS = 4,
  parameter int          SCR_AW    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              flt_valid,
  input  logic              flt_read,
  input  logic [31:0]       flt_addr,
  output logic              xlat_enable,
  output logic [31:0]       win_start,
  output logic              irq
);
  import dmat_pkg::*;

  localparam int IDX_W  = ADDR_W - 2;
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IDX_W-1:0] I_CTRL   = IDX_W'(IX_CTRL);
  localparam logic [IDX_W-1:0] I_BASE   = IDX_W'(IX_BASE);
  localparam logic [IDX_W-1:0] I_TLBF   = IDX_W'(IX_TLBF);
  localparam logic [IDX_W-1:0] I_PGF    = IDX_W'(IX_PGF);
  localparam logic [IDX_W-1:0] I_FSTAT  = IDX_W'(IX_FSTAT);
  localparam logic [IDX_W-1:0] I_FADDR  = IDX_W'(IX_FADDR);
  localparam logic [IDX_W-1:0] I_ARB    = IDX_W'(IX_ARB);
  localparam logic [IDX_W-1:0] I_SLOT0  = IDX_W'(IX_SLOT0);
  localparam logic [IDX_W-1:0] I_SLOTN  = IDX_W'(IX_SLOT0 + NUM_SLOTS);
  localparam logic [IDX_W-1:0] I_ARBEN  = IDX_W'(IX_ARBEN);
  localparam logic [IDX_W-1:0] I_MASKID = IDX_W'(IX_MASKID);
  localparam logic [31:0] VER_WORD = {VERSION, 24'h0};

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;
  logic             wr, rd;
  logic hit_ctrl, hit_base, hit_tlbf, hit_pgf, hit_fstat, hit_faddr;
  logic hit_arb, hit_slot, hit_arben, hit_maskid, named;
  logic [SLOT_W-1:0] slot_sel;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr         = bus_valid & bus_write;
  assign rd         = bus_valid & ~bus_write;

  assign hit_ctrl   = (idx == I_CTRL);
  assign hit_base   = (idx == I_BASE);
  assign hit_tlbf   = (idx == I_TLBF);
  assign hit_pgf    = (idx == I_PGF);
  assign hit_fstat  = (idx == I_FSTAT);
  assign hit_faddr  = (idx == I_FADDR);
  assign hit_arb    = (idx == I_ARB);
  assign hit_slot   = (idx >= I_SLOT0) && (idx < I_SLOTN);
  assign hit_arben  = (idx == I_ARBEN);
  assign hit_maskid = (idx == I_MASKID);
  assign slot_sel   = SLOT_W'(idx - I_SLOT0);
  assign named = hit_ctrl | hit_base | hit_tlbf | hit_pgf | hit_fstat |
                 hit_faddr | hit_arb | hit_slot | hit_arben | hit_maskid;

  logic [31:0] ctrl_q, base_q, tlbf_q, pgf_q, arb_q, arben_q, maskid_q;
  logic [31:0] slot_q [NUM_SLOTS];
  logic [31:0] fstat_q, faddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= VER_WORD;
      base_q   <= '0;
      tlbf_q   <= '0;
      pgf_q    <= '0;
      arb_q    <= ARB_RST;
      arben_q  <= ARBEN_FORCE;
      maskid_q <= MASKID_RST;
    end else if (wr) begin
      if (hit_ctrl)   ctrl_q   <= (bus_wdata & CTRL_KEEP) | VER_WORD;
      if (hit_base)   base_q   <= bus_wdata & BASE_KEEP;
      if (hit_tlbf)   tlbf_q   <= bus_wdata;
      if (hit_pgf)    pgf_q    <= bus_wdata;
      if (hit_arb)    arb_q    <= (bus_wdata & ARB_KEEP) | ARB_FORCE;
      if (hit_arben)  arben_q  <= (bus_wdata & ARBEN_KEEP) | ARBEN_FORCE;
      if (hit_maskid) maskid_q <= maskid_q | (bus_wdata & MASKID_KEEP);
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[s] <= '0;
      else if (wr && hit_slot && slot_sel == SLOT_W'(s))
        slot_q[s] <= bus_wdata & SLOT_KEEP;
    end
  end

  dmat_fault_regs u_fault (
    .clk      (clk),
    .rst      (rst),
    .flt_valid(flt_valid),
    .flt_read (flt_read),
    .flt_addr (flt_addr),
    .wr_stat  (wr & hit_fstat),
    .wr_addr  (wr & hit_faddr),
    .sw_touch (bus_valid & (hit_fstat | hit_faddr)),
    .wdata    (bus_wdata),
    .stat_q   (fstat_q),
    .addr_q   (faddr_q),
    .irq      (irq)
  );

  logic [31:0] ram_rdata;
  dmat_scratch_ram #(.AW(SCR_AW)) u_scratch (
    .clk  (clk),
    .we   (wr & ~named),
    .addr (idx[SCR_AW-1:0]),
    .wdata(bus_wdata),
    .rdata(ram_rdata)
  );

  dmat_window_decode u_win (
    .range_sel(ctrl_q[4:2]),
    .start    (win_start)
  );
  assign xlat_enable = ctrl_q[0];

  logic [31:0] rd_mux, rd_named_q;
  logic        named_q, rvalid_q;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)   rd_mux = ctrl_q;
    if (hit_base)   rd_mux = base_q;
    if (hit_tlbf)   rd_mux = tlbf_q;
    if (hit_pgf)    rd_mux = pgf_q;
    if (hit_fstat)  rd_mux = fstat_q;
    if (hit_faddr)  rd_mux = faddr_q;
    if (hit_arb)    rd_mux = arb_q;
    if (hit_slot)   rd_mux = slot_q[slot_sel];
    if (hit_arben)  rd_mux = arben_q;
    if (hit_maskid) rd_mux = maskid_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_named_q <= '0;
      named_q    <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      rd_named_q <= rd_mux;
      named_q    <= named;
      rvalid_q   <= rd;
    end
  end

  assign bus_rdata  = named_q ? rd_named_q : ram_rdata;
  assign bus_rvalid = rvalid_q;

  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid);

  // R9
  maskid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((maskid_q & $past(maskid_q)) == $past(maskid_q)));

  // R6
  arb_force_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_arb) |=> arb_q[0]);
endmodule

// File: tb/dmat_regbank_bench.sv
`timescale 1ns/1ps
module dmat_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        flt_valid = 1'b0, flt_read = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        xlat_enable, irq;
  logic [31:0] win_start;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dmat_regbank u_dmat_regbank (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .flt_valid(flt_valid), .flt_read(flt_read),
    .flt_addr(flt_addr), .xlat_enable(xlat_enable), .win_start(win_start),
    .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic rdchk(string tag, logic [13:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic fault(logic isrd, logic [31:0] a);
    @(negedge clk);
    flt_valid = 1; flt_read = isrd; flt_addr = a;
    @(negedge clk);
    flt_valid = 0;
  endtask

  task automatic t_reset();
    chk("R2 irq", {31'b0, irq}, 0);
    chk("R2 enable", {31'b0, xlat_enable}, 0);
    chk("R4 reset window", win_start, 32'hFF00_0000);
    rdchk("R2 ctrl", 14'h0000, 32'h0400_0000);
    rdchk("R2 base", 14'h0004, 0);
    rdchk("R2 fstat", 14'h1000, 32'h0080_0000);
    rdchk("R2 arb", 14'h1008, 32'h0000_0003);
    rdchk("R2 arben", 14'h2000, 32'h0000_0008);
    rdchk("R2 maskid", 14'h3018, 32'h2300_0000);
  endtask

  task automatic t_ctrl();
    wr(14'h0000, 32'hFFFF_FFFF);
    rdchk("R3 ctrl mask", 14'h0000, 32'h0400_001D);
    chk("R3 enable", {31'b0, xlat_enable}, 1);
    for (int r = 0; r < 8; r++) begin
      wr(14'h0000, 32'(r) << 2);
      chk("R4 window", win_start, 32'hFFFF_FFFF << (24 + r));
    end
    chk("R3 enable off", {31'b0, xlat_enable}, 0);
  endtask

  task automatic t_masks();
    wr(14'h0004, 32'hFFFF_FFFF);
    rdchk("R5 base", 14'h0004, 32'h07FF_FC00);
    wr(14'h0014, 32'hDEAD_BEEF);
    wr(14'h0018, 32'h1234_5678);
    rdchk("R5 tlbflush", 14'h0014, 32'hDEAD_BEEF);
    rdchk("R5 pgflush", 14'h0018, 32'h1234_5678);
    wr(14'h1010, 32'hFFFF_FFFF);
    wr(14'h1014, 32'h0000_0002);
    wr(14'h1018, 32'h0001_0000);
    wr(14'h101C, 32'h0000_0005);
    rdchk("R5 slot0", 14'h1010, 32'h0001_0003);
    rdchk("R5 slot1", 14'h1014, 32'h0000_0002);
    rdchk("R5 slot2", 14'h1018, 32'h0001_0000);
    rdchk("R5 slot3", 14'h101C, 32'h0000_0001);
  endtask

  task automatic t_arb();
    wr(14'h1008, 32'h0);
    rdchk("R6 arb force", 14'h1008, 32'h0000_0001);
    wr(14'h1008, 32'hFFFF_FFFF);
    rdchk("R6 arb mask", 14'h1008, 32'h801F_000F);
    wr(14'h2000, 32'h0);
    rdchk("R6 arben force", 14'h2000, 32'h0000_0008);
    wr(14'h2000, 32'hFFFF_FFFF);
    rdchk("R6 arben mask", 14'h2000, 32'h001F_0008);
  endtask

  task automatic t_maskid();
    wr(14'h3018, 32'h0000_0F00);
    rdchk("R9 or1", 14'h3018, 32'h2300_0F00);
    wr(14'h3018, 32'h0000_00F0);
    rdchk("R9 or2", 14'h3018, 32'h2300_0FF0);
    wr(14'h3018, 32'hFF00_0000);
    rdchk("R9 masked", 14'h3018, 32'h2300_0FF0);
  endtask

  task automatic t_fault();
    fault(1'b1, 32'h8012_3ABC);
    chk("R10 irq raised", {31'b0, irq}, 1);
    rdchk("R10 stat read", 14'h1000, 32'hC086_0000);
    chk("R8 read clears", {31'b0, irq}, 0);
    fault(1'b0, 32'h8000_5FFF);
    rdchk("R10 addr page", 14'h1004, 32'h8000_5000);
    chk("R8 addr read clears", {31'b0, irq}, 0);
    rdchk("R10 stat write-fault", 14'h1000, 32'hC082_0000);
    fault(1'b0, 32'h0000_1000);
    chk("R10 irq again", {31'b0, irq}, 1);
    wr(14'h1000, 32'h0);
    chk("R8 write clears", {31'b0, irq}, 0);
    rdchk("R7 stat force", 14'h1000, 32'h0080_0000);
    wr(14'h1000, 32'hFFFF_FFFF);
    rdchk("R7 stat mask", 14'h1000, 32'hFF8F_FFFF);
    wr(14'h1004, 32'h1234_5678);
    rdchk("R7 addr full", 14'h1004, 32'h1234_5678);
  endtask

  task automatic t_collide();
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 14'h1000; bus_wdata = 32'h0;
    flt_valid = 1; flt_read = 1; flt_addr = 32'hFFFF_E123;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; flt_valid = 0;
    chk("R11 irq kept", {31'b0, irq}, 1);
    rdchk("R11 stat", 14'h1000, 32'hC086_0000);
    rdchk("R11 addr", 14'h1004, 32'hFFFF_E000);
  endtask

  task automatic t_scratch();
    wr(14'h0100, 32'hA5A5_0001);
    wr(14'h0104, 32'h5A5A_0002);
    rdchk("R12 scratch0", 14'h0100, 32'hA5A5_0001);
    rdchk("R12 scratch1", 14'h0104, 32'h5A5A_0002);
    rdchk("R12 ctrl intact", 14'h0000, 32'h0400_001C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ctrl();
    t_masks();
    t_arb();
    t_maskid();
    t_fault();
    t_collide();
    t_scratch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule